// File: doc/BRIEF.md
# Serial Interrupt Host Frame Controller

This block is the host end of a serialized interrupt scheme that carries many interrupt levels over one shared, pulled-up, tri-state line. The line is synchronous to the bus clock. The host opens each transfer with a start frame, in which it drives the line low. It then leaves the line to the peripherals for 21 data slots. Each slot has three clocks: sample, recovery and turnaround. The host closes the transfer with a stop frame. The length of the stop frame tells every peripheral which mode comes next.

In continuous mode the host starts every transfer by itself, one after another. In quiet mode the line stays released until a peripheral pulls it low for one clock. The host then finishes that start frame. The host reads the level sampled in each slot and returns it on a 21-bit vector. That vector changes only once per transfer, so the rest of the chip sees a consistent snapshot. Routing these levels into an interrupt controller, and the pad that performs the tri-state, are outside this block.

Top module: `sirq_host`

## Requirements
- R1: While reset is asserted and on the first clock after it, `line_oe` is 0 and `irq_level` is all zeros. A reset applied in the middle of a transfer returns the block to this state.
- R2: Each stretch of host-driven low is followed by exactly one clock of driven high (`line_oe`=1, `line_out`=1), and then one clock with the line released (`line_oe`=0).
- R3: In continuous mode (`quiet_mode`=0) the host starts a transfer without any request and drives the line low for 4 clocks.
- R4: In quiet mode (`quiet_mode`=1), once a stop frame has selected quiet, the host keeps the line released until it samples `line_in` low. It then drives the line low for 3 further clocks, which makes a 4-clock start frame together with the peripheral's clock.
- R5: After the start frame's turnaround there are 21 slots of 3 clocks each. The line is released in every one of them, and `line_in` is sampled in the first clock of each slot.
- R6: Bit k of `irq_level` holds slot k, with 1 meaning that low was sampled (asserted). The slot map is: bit 0 IRQ0, bit 1 IRQ1, bit 2 SMI#, bits 3 to 15 IRQ3 to IRQ15, bit 16 IOCHK#, bits 17 to 20 PCI interrupts A to D.
- R7: The stop frame drives the line low for 2 clocks when `quiet_mode` is 1 at the end of the last slot, and for 3 clocks when it is 0.
- R8: `irq_level` keeps its previous value during the slots. It takes the new values on the first clock of the stop frame.
- R9: After the stop frame's turnaround, a continuous selection starts the next start frame on the very next clock. A quiet selection returns the host to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | 1 | Sampled value of the shared line |
| quiet_mode | input | 1 | 1 selects quiet mode, 0 selects continuous mode |
| line_out | output | 1 | Value the host drives on the line |
| line_oe | output | 1 | Host drive enable; 0 releases the line |
| irq_level | output | 21 | Decoded interrupt levels, one bit per slot, 1 = asserted |

## Verification
The bench acts as a peripheral on the modelled line and times every host-driven stretch. A controller that miscounts its start or stop length, or that shortens the start frame after a peripheral request, fails on the low-run counts. The bench asserts the first and last slots and alternating patterns, so an off-by-one in the slot index or a sample taken in the wrong phase shows up as shifted or missing bits in `irq_level`. The bench also reads `irq_level` in the middle of a transfer, which catches a design that publishes levels before the stop frame. It watches idle quiet periods, which catches a host that starts on its own when it should wait.

// File: rtl/sirq_host.sv
`timescale 1ns/1ps
module sirq_host #(
  parameter int NSLOT     = 21,
  parameter int START_LEN = 4,
  parameter int QSTOP_LEN = 2,
  parameter int CSTOP_LEN = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_in,
  input  logic             quiet_mode,
  output logic             line_out,
  output logic             line_oe,
  output logic [NSLOT-1:0] irq_level
);
  localparam int IW = $clog2(NSLOT);
  localparam int CW = $clog2(START_LEN + CSTOP_LEN + 1);

  typedef enum logic [2:0] {IDLE, STRT, SREC, STA, SLOT, STOP, PREC, PTA} st_t;

  st_t              st;
  logic [CW-1:0]    cnt;
  logic [1:0]       ph;
  logic [IW-1:0]    idx;
  logic [NSLOT-1:0] shadow;
  logic             stop_q;
  logic [CW-1:0]    stop_last;

  assign stop_last = stop_q ? CW'(QSTOP_LEN - 1) : CW'(CSTOP_LEN - 1);
  assign line_oe   = (st == STRT) || (st == SREC) || (st == STOP) || (st == PREC);
  assign line_out  = (st == SREC) || (st == PREC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= IDLE;
      cnt       <= '0;
      ph        <= '0;
      idx       <= '0;
      shadow    <= '0;
      stop_q    <= 1'b0;
      irq_level <= '0;
    end else begin
      case (st)
        IDLE:
          if (!quiet_mode) begin
            st  <= STRT;
            cnt <= '0;
          end else if (!line_in) begin
            st  <= STRT;
            cnt <= CW'(1);
          end
        STRT:
          if (cnt == CW'(START_LEN - 1)) st <= SREC;
          else cnt <= cnt + 1'b1;
        SREC: st <= STA;
        STA: begin
          st  <= SLOT;
          ph  <= '0;
          idx <= '0;
        end
        SLOT: begin
          if (ph == 2'd0) shadow[idx] <= ~line_in;
          if (ph == 2'd2) begin
            ph <= '0;
            if (idx == IW'(NSLOT - 1)) begin
              st        <= STOP;
              cnt       <= '0;
              stop_q    <= quiet_mode;
              irq_level <= shadow;
            end else begin
              idx <= idx + 1'b1;
            end
          end else begin
            ph <= ph + 1'b1;
          end
        end
        STOP:
          if (cnt == stop_last) st <= PREC;
          else cnt <= cnt + 1'b1;
        PREC: st <= PTA;
        PTA:
          if (stop_q) st <= IDLE;
          else begin
            st  <= STRT;
            cnt <= '0;
          end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

module sirq_host_chk #(
  parameter int NSLOT = 21
) (
  input logic             clk,
  input logic             rst_n,
  input logic             line_out,
  input logic             line_oe,
  input logic [NSLOT-1:0] irq_level
);
  logic       drv_low, drv_hi;
  logic [3:0] run;

  assign drv_low = line_oe && !line_out;
  assign drv_hi  = line_oe && line_out;

  always_ff @(posedge clk) begin
    if (!rst_n) run <= '0;
    else if (drv_low) run <= run + 1'b1;
    else run <= '0;
  end

  AST_HIGH_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(drv_low) && !drv_low) |-> drv_hi); // R2
  AST_RELEASE_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $past(drv_hi) |-> !line_oe); // R2
  AST_LOW_RUN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    drv_low |-> (run < 4'd4)); // R3
  AST_LEVEL_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(irq_level) |-> drv_low); // R8
  AST_RESET_RELEASED: assert property (@(posedge clk)
    !rst_n |=> !line_oe); // R1
endmodule

bind sirq_host sirq_host_chk #(.NSLOT(NSLOT)) chk_i (
  .clk(clk), .rst_n(rst_n), .line_out(line_out), .line_oe(line_oe), .irq_level(irq_level)
);

// File: tb/sirq_host_tb.sv
`timescale 1ns/1ps
module sirq_host_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic quiet_mode = 1'b0;
  logic periph_low = 1'b0;
  logic line_in, line_out, line_oe;
  logic [20:0] irq_level;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;
  assign line_in = line_oe ? line_out : !periph_low;

  sirq_host dut_i (.clk(clk), .rst_n(rst_n), .line_in(line_in), .quiet_mode(quiet_mode),
                   .line_out(line_out), .line_oe(line_oe), .irq_level(irq_level));

  // {quiet selected by the stop frame, slot pattern (1 = peripheral pulls low)}
  localparam logic [21:0] VEC [6] = '{
    {1'b0, 21'h000000},
    {1'b0, 21'h1FFFFF},
    {1'b1, 21'h15A5A5},
    {1'b1, 21'h000005},
    {1'b0, 21'h1E0000},
    {1'b0, 21'h110001}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_frame(input logic [21:0] v, input bit quiet_start, input bit first,
                           input logic [20:0] prev);
    int n;
    if (quiet_start) begin
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        chk(!line_oe, "R4 quiet idle released", 32'(line_oe), 0);
      end
      periph_low = 1'b1;
      @(negedge clk);
      periph_low = 1'b0;
    end else begin
      n = 0;
      while (!(line_oe && !line_out) && n < 40) begin
        @(negedge clk);
        n++;
      end
      if (!first) chk(n == 1, "R9 continuous restart delay", 32'(n), 1);
    end
    n = 0;
    while (line_oe && !line_out && n < 10) begin
      n++;
      @(negedge clk);
    end
    if (quiet_start) chk(n == 3, "R4 host low after request", 32'(n), 3);
    else chk(n == 4, "R3 start low length", 32'(n), 4);
    chk(line_oe && line_out, "R2 start recovery high", {30'd0, line_oe, line_out}, 3);
    @(negedge clk);
    chk(!line_oe, "R2 start turnaround released", 32'(line_oe), 0);
    quiet_mode = v[21];
    for (int i = 0; i < 21; i++) begin
      @(negedge clk);
      chk(!line_oe, "R5 slot sample released", 32'(line_oe), 0);
      periph_low = v[i];
      @(negedge clk);
      periph_low = 1'b0;
      if (i == 10) chk(irq_level == prev, "R8 level held mid transfer", 32'(irq_level), 32'(prev));
      @(negedge clk);
      chk(!line_oe, "R5 slot turnaround released", 32'(line_oe), 0);
    end
    @(negedge clk);
    n = 0;
    while (line_oe && !line_out && n < 10) begin
      n++;
      @(negedge clk);
    end
    chk(n == (v[21] ? 2 : 3), "R7 stop low length", 32'(n), v[21] ? 2 : 3);
    chk(irq_level == v[20:0], "R6 decoded levels", 32'(irq_level), 32'(v[20:0]));
    chk(line_oe && line_out, "R2 stop recovery high", {30'd0, line_oe, line_out}, 3);
    @(negedge clk);
    chk(!line_oe, "R2 stop turnaround released", 32'(line_oe), 0);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [20:0] prev;
    bit qs;
    repeat (3) @(negedge clk);
    chk(!line_oe, "R1 reset released", 32'(line_oe), 0);
    chk(irq_level == 21'd0, "R1 reset levels", 32'(irq_level), 0);
    rst_n = 1'b1;
    prev = '0;
    qs = 1'b0;
    for (int e = 0; e < 6; e++) begin
      run_frame(VEC[e], qs, (e == 0) || qs, prev);
      prev = VEC[e][20:0];
      qs = VEC[e][21];
    end
    // quiet selection: host must stay idle without a request (R9)
    quiet_mode = 1'b1;
    run_frame({1'b1, 21'h100001}, 1'b0, 1'b0, prev);
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      chk(!line_oe, "R9 idle after quiet stop", 32'(line_oe), 0);
    end
    // reset in the middle of a transfer
    periph_low = 1'b1;
    @(negedge clk);
    periph_low = 1'b0;
    repeat (20) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!line_oe, "R1 mid reset released", 32'(line_oe), 0);
    chk(irq_level == 21'd0, "R1 mid reset levels", 32'(irq_level), 0);
    quiet_mode = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    run_frame({1'b0, 21'h0AAAAA}, 1'b0, 1'b1, 21'd0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule